// File: doc/BRIEF.md
# Priority-Split Read Command Queue

This block holds pending read commands for a memory controller and hands out one of them per cycle. Its entries are divided into two regions at a boundary that can be set while the queue is empty. The lower entries hold low-priority reads, and the upper entries hold high-priority reads. Each command arrives with a class bit and a bank, row and column address. The command is written into a free entry of its own class's region.

Every cycle the block presents one stored command on a valid/ready issue port. The choice uses three keys in order:
- Class comes first: any high-priority entry wins over all low-priority entries.
- Page status comes next: within a class, an entry whose row is currently open in its bank wins over one that would need an activate.
- Age decides ties: the entry that arrived first goes out.

The open-row information comes from a live per-bank status input. A page hit is therefore judged against the bank state of the current cycle.

Top module: `prio_read_queue`

## Requirements
- R1: After reset the queue is empty, `out_valid` is 0, and both classes report `in_ready` = 1. The low-priority region size after reset is DEPTH/2, which is 4 entries at the defaults.
- R2: With a region size L, entries 0..L-1 take only low-priority commands (`in_hp` = 0) and entries L..DEPTH-1 take only high-priority commands (`in_hp` = 1). A class whose region is empty (L = 0 for low, L = DEPTH for high) never accepts.
- R3: `in_ready` for the class selected by `in_hp` is 1 exactly when that class's region has a free entry. A full region for one class does not block the other class.
- R4: While any high-priority entry is stored, no low-priority entry is issued.
- R5: Within the winning class, an entry whose bank is open (`bank_open` bit set) with `open_rows` for that bank equal to its row is issued before any entry of that class without a hit.
- R6: Among entries equal in class and hit status, the one enqueued earliest is issued first.
- R7: `out_valid` is 1 whenever an entry is stored. A cycle with `out_valid` and `out_ready` both 1 frees exactly one entry, the presented one, and its bank, row, column and class appear on the outputs in that cycle.
- R8: A `cfg_load` pulse sets the region size to `cfg_lp_num`, with values above DEPTH saturating to DEPTH, only when the queue is empty. In that cycle `in_ready` is 0. A pulse while entries are stored is ignored.
- R9: `out_hit` is 1 when the presented entry is a page hit under the current bank status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Request to load a new low-priority region size |
| cfg_lp_num | input | CNT_W | Requested low-priority entry count |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Region of the offered class can take it |
| in_hp | input | 1 | 1 = high-priority read, 0 = low-priority read |
| in_bank | input | BANK_W | Bank address |
| in_row | input | ROW_W | Row address |
| in_col | input | COL_W | Column address |
| bank_open | input | BANKS | Per-bank open-row flag |
| open_rows | input | BANKS*ROW_W | Open row of each bank, bank 0 in the low bits |
| out_valid | output | 1 | A command is presented |
| out_ready | input | 1 | Consumer takes the presented command |
| out_hp | output | 1 | Class of the presented command |
| out_hit | output | 1 | Presented command hits an open row |
| out_bank | output | BANK_W | Bank of the presented command |
| out_row | output | ROW_W | Row of the presented command |
| out_col | output | COL_W | Column of the presented command |

## Verification
A corrupted age relation shows up as two same-class, same-hit commands issuing in swapped order. This appears on `out_col` on the first pop that involves those two entries. A wrong region boundary or a lost valid bit shows up in `in_ready` during the first probe after the region should have filled, or as a missing or duplicated command while the queue drains. Each entry's column number is unique inside a scenario, so one sample of `out_col` per pop exposes a wrong selection in the cycle it happens.

// File: rtl/prq_pkg.sv
// Package: default sizes shared by the read queue and its bench.
// Assumes nothing; holds constants only.
package prq_pkg;
    localparam int DEF_DEPTH = 8;
    localparam int DEF_BANKS = 4;
    localparam int DEF_ROW_W = 8;
    localparam int DEF_COL_W = 6;
endpackage

// File: rtl/prq_slot_find.sv
// Module: finds the lowest-index free entry in a mask.
// Assumes the caller has already restricted the mask to one region.
module prq_slot_find #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] free_mask,
    output logic [DEPTH-1:0] slot_oh,
    output logic             slot_any
);
    // Purpose: one-hot of the lowest set bit of free_mask.
    always_comb begin
        logic found;
        found   = 1'b0;
        slot_oh = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (free_mask[i] && !found) begin
                slot_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign slot_any = |free_mask;
endmodule

// File: rtl/prq_pick.sv
// Module: narrows the stored entries to the issue candidates.
// Class first (high beats low), then page hit within that class.
// Assumes hit_vec is meaningful only where valid_vec is set.
module prq_pick #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] valid_vec,
    input  logic [DEPTH-1:0] hp_mask,
    input  logic [DEPTH-1:0] hit_vec,
    output logic [DEPTH-1:0] cand_vec
);
    logic [DEPTH-1:0] hp_set;
    logic [DEPTH-1:0] cls_set;
    logic [DEPTH-1:0] hit_set;

    // Purpose: choose the class, then prefer hits within it.
    always_comb begin
        hp_set   = valid_vec & hp_mask;
        cls_set  = (|hp_set) ? hp_set : (valid_vec & ~hp_mask);
        hit_set  = cls_set & hit_vec;
        cand_vec = (|hit_set) ? hit_set : cls_set;
    end
endmodule

// File: rtl/prq_age_matrix.sv
// Module: age matrix over all entries; picks the oldest candidate.
// older_q[i][j] = 1 means entry i arrived before entry j.
// Assumes at most one allocation per cycle (one-hot alloc_oh).
module prq_age_matrix #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] alloc_oh,
    input  logic [DEPTH-1:0] cand_vec,
    output logic [DEPTH-1:0] win_oh
);
    logic [DEPTH-1:0] older_q [DEPTH];

    // Purpose: a new entry is younger than every other entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (alloc_oh[k]) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        older_q[k][j] <= 1'b0;
                        if (j != k) older_q[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    // Purpose: a candidate wins when no other candidate is older.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && cand_vec[j] && older_q[j][i]) beaten = 1'b1;
            end
            win_oh[i] = cand_vec[i] && !beaten;
        end
    end
endmodule

// File: rtl/prio_read_queue.sv
// Module: read command store split into low- and high-priority regions.
// Entries below lp_num_q are low priority; the rest are high priority.
// Issues one entry per cycle by class, page hit, then age.
// Assumes open_rows/bank_open describe the bank state of the current cycle.
module prio_read_queue #(
    parameter int DEPTH    = prq_pkg::DEF_DEPTH,
    parameter int BANKS    = prq_pkg::DEF_BANKS,
    parameter int ROW_W    = prq_pkg::DEF_ROW_W,
    parameter int COL_W    = prq_pkg::DEF_COL_W,
    parameter int LP_RESET = DEPTH / 2,
    localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load,
    input  logic [CNT_W-1:0]       cfg_lp_num,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_hp,
    input  logic [BANK_W-1:0]      in_bank,
    input  logic [ROW_W-1:0]       in_row,
    input  logic [COL_W-1:0]       in_col,
    input  logic [BANKS-1:0]       bank_open,
    input  logic [BANKS*ROW_W-1:0] open_rows,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic                   out_hp,
    output logic                   out_hit,
    output logic [BANK_W-1:0]      out_bank,
    output logic [ROW_W-1:0]       out_row,
    output logic [COL_W-1:0]       out_col
);
    logic [DEPTH-1:0]  valid_q;
    logic [CNT_W-1:0]  lp_num_q;
    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [ROW_W-1:0]  row_q  [DEPTH];
    logic [COL_W-1:0]  col_q  [DEPTH];

    logic [DEPTH-1:0]  hp_mask;
    logic [DEPTH-1:0]  hit_vec;
    logic [DEPTH-1:0]  free_mask;
    logic [DEPTH-1:0]  alloc_oh;
    logic [DEPTH-1:0]  alloc_fire;
    logic [DEPTH-1:0]  cand_vec;
    logic [DEPTH-1:0]  win_oh;
    logic              slot_any;
    logic              cfg_apply;
    logic              in_fire;
    logic              out_fire;
    logic [CNT_W-1:0]  cfg_sat;

    // Per-entry region membership and live page-hit status.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign hp_mask[g] = (CNT_W'(g) >= lp_num_q);
        assign hit_vec[g] = bank_open[bank_q[g]] &&
                            (open_rows[bank_q[g]*ROW_W +: ROW_W] == row_q[g]);
    end

    // Purpose: free entries inside the region of the offered class.
    assign free_mask = ~valid_q & (in_hp ? hp_mask : ~hp_mask);

    prq_slot_find #(.DEPTH(DEPTH)) slot_i (
        .free_mask (free_mask),
        .slot_oh   (alloc_oh),
        .slot_any  (slot_any)
    );

    // Purpose: split reload allowed only on an empty queue, saturated to DEPTH.
    assign cfg_apply = cfg_load && (valid_q == '0);
    assign cfg_sat   = (cfg_lp_num > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cfg_lp_num;

    assign in_ready   = slot_any && !cfg_apply;
    assign in_fire    = in_valid && in_ready;
    assign alloc_fire = in_fire ? alloc_oh : '0;

    prq_pick #(.DEPTH(DEPTH)) pick_i (
        .valid_vec (valid_q),
        .hp_mask   (hp_mask),
        .hit_vec   (hit_vec),
        .cand_vec  (cand_vec)
    );

    prq_age_matrix #(.DEPTH(DEPTH)) age_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_oh (alloc_fire),
        .cand_vec (cand_vec),
        .win_oh   (win_oh)
    );

    // Purpose: present the fields of the winning entry.
    always_comb begin
        out_bank = '0;
        out_row  = '0;
        out_col  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (win_oh[i]) begin
                out_bank = out_bank | bank_q[i];
                out_row  = out_row  | row_q[i];
                out_col  = out_col  | col_q[i];
            end
        end
    end

    assign out_valid = |win_oh;
    assign out_hp    = |(win_oh & hp_mask);
    assign out_hit   = |(win_oh & hit_vec);
    assign out_fire  = out_valid && out_ready;

    // Purpose: occupancy and region size state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            lp_num_q <= CNT_W'(LP_RESET);
        end else begin
            valid_q <= (valid_q & ~(out_fire ? win_oh : '0)) | alloc_fire;
            if (cfg_apply) lp_num_q <= cfg_sat;
        end
    end

    // Purpose: capture command fields into the allocated entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc_fire[i]) begin
                bank_q[i] <= in_bank;
                row_q[i]  <= in_row;
                col_q[i]  <= in_col;
            end
        end
    end
endmodule

// File: rtl/prq_checker.sv
// Module: property checks on the read queue, bound to every instance.
// Assumes its inputs are the queue's ports and occupancy/region state.
module prq_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_hp,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_hp,
    input logic [DEPTH-1:0] valid_q,
    input logic [DEPTH-1:0] hp_mask,
    input logic [CNT_W-1:0] lp_num_q
);
    a_r2_hp_region: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_hp) |=>
            ((valid_q & ~$past(valid_q) & ~$past(hp_mask)) == '0));

    a_r2_lp_region: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_hp) |=>
            ((valid_q & ~$past(valid_q) & $past(hp_mask)) == '0));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(out_valid && out_ready)) |=>
            ($countones(valid_q) == $countones($past(valid_q)) + 1));

    a_r4_hp_first: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hp) |-> ((valid_q & hp_mask) == '0));

    a_r7_one_free: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !(in_valid && in_ready)) |=>
            ($countones(valid_q) == $countones($past(valid_q)) - 1));

    a_r8_split_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q != '0) |-> $stable(lp_num_q));
endmodule

bind prio_read_queue prq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_hp     (in_hp),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_hp    (out_hp),
    .valid_q   (valid_q),
    .hp_mask   (hp_mask),
    .lp_num_q  (lp_num_q)
);

// File: tb/prio_read_queue_tb.sv
`timescale 1ns/1ps
module prio_read_queue_tb_top;
    localparam int DEPTH = 8;
    localparam int CNT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [3:0]  cfg_lp_num = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_hp = 1'b0;
    logic [1:0]  in_bank = '0;
    logic [7:0]  in_row = '0;
    logic [5:0]  in_col = '0;
    logic [3:0]  bank_open = '0;
    logic [31:0] open_rows = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_hp;
    logic        out_hit;
    logic [1:0]  out_bank;
    logic [7:0]  out_row;
    logic [5:0]  out_col;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_read_queue dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lp_num(cfg_lp_num),
        .in_valid(in_valid), .in_ready(in_ready), .in_hp(in_hp),
        .in_bank(in_bank), .in_row(in_row), .in_col(in_col),
        .bank_open(bank_open), .open_rows(open_rows),
        .out_valid(out_valid), .out_ready(out_ready), .out_hp(out_hp),
        .out_hit(out_hit), .out_bank(out_bank), .out_row(out_row), .out_col(out_col)
    );

    // Vector: {enq hp, bank, row, col, expected issue col, expected hp, expected hit}
    localparam logic [24:0] VEC [0:7] = '{
        {1'b0, 2'd0, 8'd5, 6'd1, 6'd5, 1'b1, 1'b1},
        {1'b0, 2'd2, 8'd1, 6'd2, 6'd8, 1'b1, 1'b1},
        {1'b1, 2'd1, 8'd9, 6'd3, 6'd3, 1'b1, 1'b0},
        {1'b0, 2'd3, 8'd3, 6'd4, 6'd6, 1'b1, 1'b0},
        {1'b1, 2'd0, 8'd5, 6'd5, 6'd1, 1'b0, 1'b1},
        {1'b1, 2'd2, 8'd4, 6'd6, 6'd4, 1'b0, 1'b1},
        {1'b0, 2'd1, 8'd7, 6'd7, 6'd7, 1'b0, 1'b1},
        {1'b1, 2'd3, 8'd3, 6'd8, 6'd2, 1'b0, 1'b0}
    };

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic enq(input logic hp, input logic [1:0] b, input logic [7:0] r,
                       input logic [5:0] c, input logic exp_rdy, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_hp = hp; in_bank = b; in_row = r; in_col = c;
        #1 check(int'(in_ready), int'(exp_rdy), req);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic probe(input logic hp, input logic exp_rdy, input string req);
        @(negedge clk);
        in_valid = 1'b0; in_hp = hp;
        #1 check(int'(in_ready), int'(exp_rdy), req);
    endtask

    task automatic pop(input logic [5:0] c, input logic hp, input string req);
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        check(int'(out_valid), 1, req);
        check(int'(out_col), int'(c), req);
        check(int'(out_hp), int'(hp), req);
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    task automatic load_split(input logic [3:0] v, input logic exp_rdy, input string req);
        @(negedge clk);
        cfg_load = 1'b1; cfg_lp_num = v; in_hp = 1'b1;
        #1 check(int'(in_ready), int'(exp_rdy), req);
        @(posedge clk);
        #1 cfg_load = 1'b0;
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        bank_open = 4'b1011;
        open_rows = {8'd3, 8'd0, 8'd7, 8'd5};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        #1 check(int'(out_valid), 0, "R1");
        probe(1'b0, 1'b1, "R1");
        probe(1'b1, 1'b1, "R1");

        // Table walk: fill both regions, then drain in R4/R5/R6 order
        for (int k = 0; k < 8; k++)
            enq(VEC[k][24], VEC[k][23:22], VEC[k][21:14], VEC[k][13:8], 1'b1, "R2");
        probe(1'b0, 1'b0, "R3");
        probe(1'b1, 1'b0, "R3");
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            check(int'(out_valid), 1, "R7");
            check(int'(out_col), int'(VEC[k][7:2]), "R4_R5_R6 order");
            check(int'(out_hp), int'(VEC[k][1]), "R4");
            check(int'(out_hit), int'(VEC[k][0]), "R9");
            @(posedge clk);
            #1 out_ready = 1'b0;
        end
        @(negedge clk);
        #1 check(int'(out_valid), 0, "R7");

        // R3: low region full, high class still accepted; R6 age order of misses
        for (int k = 0; k < 4; k++) enq(1'b0, 2'd2, 8'd20, 6'(10 + k), 1'b1, "R3");
        probe(1'b0, 1'b0, "R3");
        probe(1'b1, 1'b1, "R3");
        for (int k = 0; k < 4; k++) pop(6'(10 + k), 1'b0, "R6");

        // R8: reload ignored while entries are stored
        enq(1'b1, 2'd0, 8'd1, 6'd30, 1'b1, "R8");
        load_split(4'd8, 1'b1, "R8");
        pop(6'd30, 1'b1, "R8");
        for (int k = 0; k < 4; k++) enq(1'b0, 2'd2, 8'd1, 6'(40 + k), 1'b1, "R8");
        probe(1'b0, 1'b0, "R8");
        for (int k = 0; k < 4; k++) pop(6'(40 + k), 1'b0, "R8");

        // R8: reload applied on empty queue, in_ready low that cycle; R2 new boundary
        load_split(4'd6, 1'b0, "R8");
        for (int k = 0; k < 6; k++) enq(1'b0, 2'd2, 8'd1, 6'(50 + k), 1'b1, "R2");
        probe(1'b0, 1'b0, "R2");
        enq(1'b1, 2'd2, 8'd1, 6'd60, 1'b1, "R2");
        enq(1'b1, 2'd2, 8'd1, 6'd61, 1'b1, "R2");
        probe(1'b1, 1'b0, "R2");
        pop(6'd60, 1'b1, "R4");
        pop(6'd61, 1'b1, "R4");
        for (int k = 0; k < 6; k++) pop(6'(50 + k), 1'b0, "R6");

        // R8 saturation to DEPTH; R2 empty high region
        load_split(4'd15, 1'b0, "R8");
        probe(1'b1, 1'b0, "R8");
        probe(1'b0, 1'b1, "R8");
        // R2: zero-size low region
        load_split(4'd0, 1'b0, "R2");
        probe(1'b0, 1'b0, "R2");
        probe(1'b1, 1'b1, "R2");

        // R5: hit judged on live bank status
        enq(1'b1, 2'd2, 8'd4, 6'd1, 1'b1, "R5");
        enq(1'b1, 2'd2, 8'd9, 6'd2, 1'b1, "R5");
        @(negedge clk);
        #1 check(int'(out_hit), 0, "R9");
        bank_open = 4'b1111;
        open_rows = {8'd3, 8'd9, 8'd7, 8'd5};
        pop(6'd2, 1'b1, "R5");
        pop(6'd1, 1'b1, "R6");

        report();
    end
endmodule